// File: doc/BRIEF.md
# Interrupt source coalescing state array

This block keeps a two-bit coalescing state for every interrupt source in a group. It also keeps a line-assertion bit for sources configured as level-sensitive. A trigger on an idle source produces one notification carrying the source number. Further triggers are folded into a single "queued" mark until software ends the interrupt. Notifications leave through a small valid/ready queue toward a downstream router.

Software reaches the state through a load/store port. Each access names a source and a 12-bit offset inside that source's management page, and the offset selects the operation. Every load atomically returns the state held before the access. An end-of-interrupt on a queued source re-triggers it. One engine applies one operation per cycle, either a port access or one waiting trigger, so no two updates of the same source can race.

The per-source state takes four values: RESET (00, idle), PEND (10, notified and awaiting end-of-interrupt), QUEUED (11, notified with a further trigger seen) and OFF (01, masked). The engine takes one of three steps each cycle: ENG_IDLE, ENG_ACCESS (a port operation) or ENG_TRIGGER (one stored trigger request).

Top module: `evsrc_pq_array`

## Requirements
- R1: After reset every source is in RESET (00) with its assertion bit clear, no notification is offered, no read response is pending, and the access port is ready.
- R2: A trigger moves RESET to PEND and emits one notification for that source. A trigger moves PEND to QUEUED with no notification. A trigger leaves QUEUED and OFF unchanged and emits nothing.
- R3: A load at offset 0x000 ends the interrupt. It moves PEND to RESET, and it moves QUEUED to PEND while emitting a fresh notification. RESET and OFF are left unchanged.
- R4: A read response arrives exactly one cycle after each accepted load. Unless R8 applies, its bits [1:0] hold the P and Q bits from before the access, bit 2 holds the assertion bit, and all higher bits are zero.
- R5: A load at offset 0x800 returns the state and changes nothing.
- R6: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11 respectively, and emit no notification.
- R7: A store at offset 0x400 ends the interrupt exactly as R3 does, but only while store-EOI is enabled. Every other store, and any store while store-EOI is disabled, changes nothing. No store produces a read response.
- R8: A load at any offset not named in R3, R5 or R6 returns all ones and changes nothing.
- R9: The notification queue holds its output stable while it is not accepted. While the queue is full the access port is not ready and trigger requests wait; none is lost.
- R10: For a level source, bit 2 follows the line one cycle late and a rising line acts as a trigger. An end-of-interrupt on PEND while the line is still asserted stays in PEND and notifies again.
- R11: Simultaneous trigger requests are served one per cycle, lowest source number first, and port accesses take precedence over trigger requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_SRC | One-cycle trigger pulse per edge source |
| line_i | input | NUM_SRC | Interrupt line per level source |
| level_mode_i | input | NUM_SRC | 1 = source is level-sensitive |
| store_eoi_en_i | input | 1 | Enables end-of-interrupt by store at 0x400 |
| acc_valid_i | input | 1 | Access request |
| acc_ready_o | output | 1 | Access accepted when high with acc_valid_i |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_src_i | input | SRC_W | Source number of the access |
| acc_ofs_i | input | 12 | Offset within the source page |
| acc_rvalid_o | output | 1 | Load response valid |
| acc_rdata_o | output | 64 | Load response data |
| notif_valid_o | output | 1 | Notification available |
| notif_ready_i | input | 1 | Downstream accepts notification |
| notif_src_o | output | SRC_W | Source number carried by the notification |

## Verification
The bench builds the block with four sources and a two-entry notification queue. With that queue, three simultaneous triggers fill it, so the port back-pressure, the waiting third request and the lowest-first service order all come within a few cycles of reach. Source 3 is level-sensitive and the rest are edge sources. The same build therefore covers the assertion bit, the rising-line trigger and the re-notify on end-of-interrupt alongside the plain edge transitions.

// File: rtl/evsrc_pkg.sv
package evsrc_pkg;

    typedef enum logic [1:0] {
        PQ_RESET  = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_QUEUED = 2'b11
    } pq_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GET,
        OP_EOI,
        OP_SET,
        OP_BAD,
        OP_TRIG
    } op_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ACCESS,
        ENG_TRIGGER
    } eng_e;

    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_LOAD_EOI  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_STORE_EOI = 12'h400;
    localparam logic [OFS_W-1:0] OFS_GET       = 12'h800;
    localparam logic [OFS_W-1:0] OFS_SET_00    = 12'hC00;
    localparam logic [OFS_W-1:0] OFS_SET_01    = 12'hD00;
    localparam logic [OFS_W-1:0] OFS_SET_10    = 12'hE00;
    localparam logic [OFS_W-1:0] OFS_SET_11    = 12'hF00;

endpackage

// File: rtl/evsrc_ofs_decode.sv
module evsrc_ofs_decode
    import evsrc_pkg::*;
(
    input  logic             write_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             store_eoi_en_i,
    output op_e              op_o,
    output pq_e              set_val_o
);

    always_comb begin
        op_o      = OP_NONE;
        set_val_o = PQ_RESET;
        if (write_i) begin
            if (ofs_i == OFS_STORE_EOI && store_eoi_en_i) begin
                op_o = OP_EOI;
            end
        end else begin
            unique case (ofs_i)
                OFS_LOAD_EOI: op_o = OP_EOI;
                OFS_GET:      op_o = OP_GET;
                OFS_SET_00, OFS_SET_01, OFS_SET_10, OFS_SET_11: begin
                    op_o      = OP_SET;
                    set_val_o = pq_e'(ofs_i[9:8]);
                end
                default:      op_o = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/evsrc_pq_step.sv
module evsrc_pq_step
    import evsrc_pkg::*;
(
    input  pq_e  cur_i,
    input  op_e  op_i,
    input  pq_e  set_val_i,
    input  logic level_i,
    input  logic asserted_i,
    output pq_e  nxt_o,
    output logic notify_o
);

    always_comb begin
        nxt_o    = cur_i;
        notify_o = 1'b0;
        unique case (op_i)
            OP_TRIG: begin
                unique case (cur_i)
                    PQ_RESET: begin
                        nxt_o    = PQ_PEND;
                        notify_o = 1'b1;
                    end
                    PQ_PEND:  nxt_o = PQ_QUEUED;
                    default:  nxt_o = cur_i;
                endcase
            end
            OP_EOI: begin
                unique case (cur_i)
                    PQ_PEND: begin
                        if (level_i && asserted_i) begin
                            nxt_o    = PQ_PEND;
                            notify_o = 1'b1;
                        end else begin
                            nxt_o = PQ_RESET;
                        end
                    end
                    PQ_QUEUED: begin
                        nxt_o    = PQ_PEND;
                        notify_o = 1'b1;
                    end
                    default: nxt_o = cur_i;
                endcase
            end
            OP_SET:  nxt_o = set_val_i;
            default: nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/evsrc_notify_fifo.sv
module evsrc_notify_fifo #(
    parameter  int DEPTH = 4,
    parameter  int W     = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o,
    output logic         full_o
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          pop_ok;

    assign valid_o = (count != '0);
    assign full_o  = (count == CW'(DEPTH));
    assign dout_o  = mem[rd_ptr];
    assign pop_ok  = pop_i && valid_o;

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[wr_ptr] <= din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_i, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/evsrc_pq_array.sv
module evsrc_pq_array
    import evsrc_pkg::*;
#(
    parameter  int NUM_SRC    = 16,
    parameter  int FIFO_DEPTH = 4,
    localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic [NUM_SRC-1:0] level_mode_i,
    input  logic               store_eoi_en_i,
    input  logic               acc_valid_i,
    output logic               acc_ready_o,
    input  logic               acc_write_i,
    input  logic [SRC_W-1:0]   acc_src_i,
    input  logic [OFS_W-1:0]   acc_ofs_i,
    output logic               acc_rvalid_o,
    output logic [63:0]        acc_rdata_o,
    output logic               notif_valid_o,
    input  logic               notif_ready_i,
    output logic [SRC_W-1:0]   notif_src_o
);

    pq_e [NUM_SRC-1:0]  pq_q;
    logic [NUM_SRC-1:0] asserted_q;
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] taken;
    logic               rvalid_q;
    logic [63:0]        rdata_q;

    eng_e               eng;
    logic               fifo_full_w;
    logic               push_w;
    logic               acc_fire;
    logic               load_fire;
    logic               grant_any;
    logic [SRC_W-1:0]   grant_idx;
    logic [SRC_W-1:0]   sel_src;
    op_e                dec_op;
    op_e                step_op;
    pq_e                dec_set;
    pq_e                step_nxt;
    logic               step_notify;
    logic [63:0]        load_data;

    // Trigger events: edge sources use the pulse, level sources the rising line
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_evt
        assign evt[g] = level_mode_i[g] ? (line_i[g] & ~asserted_q[g]) : trig_i[g];
    end

    // Lowest-numbered waiting request wins
    always_comb begin
        grant_any = 1'b0;
        grant_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_q[i]) begin
                grant_any = 1'b1;
                grant_idx = SRC_W'(i);
            end
        end
    end

    assign acc_ready_o = !fifo_full_w;
    assign acc_fire    = acc_valid_i && acc_ready_o;
    assign load_fire   = acc_fire && !acc_write_i;

    // Engine step selection: port access first, then one trigger request
    always_comb begin
        eng = ENG_IDLE;
        if (acc_fire) begin
            eng = ENG_ACCESS;
        end else if (grant_any && !fifo_full_w) begin
            eng = ENG_TRIGGER;
        end
    end

    evsrc_ofs_decode u_dec (
        .write_i        (acc_write_i),
        .ofs_i          (acc_ofs_i),
        .store_eoi_en_i (store_eoi_en_i),
        .op_o           (dec_op),
        .set_val_o      (dec_set)
    );

    // Engine outputs per step
    always_comb begin
        sel_src = '0;
        step_op = OP_NONE;
        taken   = '0;
        unique case (eng)
            ENG_ACCESS: begin
                sel_src = acc_src_i;
                step_op = dec_op;
            end
            ENG_TRIGGER: begin
                sel_src          = grant_idx;
                step_op          = OP_TRIG;
                taken[grant_idx] = 1'b1;
            end
            default: begin
                sel_src = '0;
                step_op = OP_NONE;
            end
        endcase
    end

    evsrc_pq_step u_step (
        .cur_i      (pq_q[sel_src]),
        .op_i       (step_op),
        .set_val_i  (dec_set),
        .level_i    (level_mode_i[sel_src]),
        .asserted_i (asserted_q[sel_src]),
        .nxt_o      (step_nxt),
        .notify_o   (step_notify)
    );

    assign push_w = (eng != ENG_IDLE) && step_notify;

    assign load_data = (dec_op == OP_BAD) ? {64{1'b1}}
                     : {61'b0, asserted_q[acc_src_i], pq_q[acc_src_i]};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                pq_q[i] <= PQ_RESET;
            end
            asserted_q <= '0;
            req_q      <= '0;
            rvalid_q   <= 1'b0;
            rdata_q    <= '0;
        end else begin
            if (eng != ENG_IDLE) begin
                pq_q[sel_src] <= step_nxt;
            end
            asserted_q <= line_i & level_mode_i;
            req_q      <= (req_q & ~taken) | evt;
            rvalid_q   <= load_fire;
            if (load_fire) begin
                rdata_q <= load_data;
            end
        end
    end

    assign acc_rvalid_o = rvalid_q;
    assign acc_rdata_o  = rdata_q;

    evsrc_notify_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (SRC_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_w),
        .din_i   (sel_src),
        .pop_i   (notif_ready_i),
        .dout_o  (notif_src_o),
        .valid_o (notif_valid_o),
        .full_o  (fifo_full_w)
    );

endmodule

// File: rtl/evsrc_pq_checker.sv
module evsrc_pq_checker #(
    parameter int NUM_SRC = 16,
    parameter int SRC_W   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid_i,
    input logic                    acc_ready_o,
    input logic                    acc_write_i,
    input logic [SRC_W-1:0]        acc_src_i,
    input logic [11:0]             acc_ofs_i,
    input logic                    acc_rvalid_o,
    input logic [63:0]             acc_rdata_o,
    input logic                    notif_valid_o,
    input logic                    notif_ready_i,
    input logic [SRC_W-1:0]        notif_src_o,
    input logic                    push_w,
    input logic                    fifo_full_w,
    input logic [NUM_SRC-1:0][1:0] pq_i
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_w |-> !fifo_full_w); // R9

    AST_NOTIF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        notif_valid_o && !notif_ready_i |=> notif_valid_o && $stable(notif_src_o)); // R9

    AST_LOAD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_ready_o && !acc_write_i |=> acc_rvalid_o); // R4

    AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_ready_o && acc_write_i |=> !acc_rvalid_o); // R7

    AST_BAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_ready_o && !acc_write_i && acc_ofs_i == 12'h400
        |=> acc_rdata_o == {64{1'b1}}); // R8

    AST_FORCE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_ready_o && !acc_write_i && acc_ofs_i == 12'hE00
        |=> pq_i[$past(acc_src_i)] == 2'b10); // R6

    AST_GET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i && acc_ready_o && !acc_write_i && acc_ofs_i == 12'h800
        |=> pq_i[$past(acc_src_i)] == $past(pq_i[acc_src_i])); // R5

endmodule

bind evsrc_pq_array evsrc_pq_checker #(
    .NUM_SRC (NUM_SRC),
    .SRC_W   (SRC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid_i   (acc_valid_i),
    .acc_ready_o   (acc_ready_o),
    .acc_write_i   (acc_write_i),
    .acc_src_i     (acc_src_i),
    .acc_ofs_i     (acc_ofs_i),
    .acc_rvalid_o  (acc_rvalid_o),
    .acc_rdata_o   (acc_rdata_o),
    .notif_valid_o (notif_valid_o),
    .notif_ready_i (notif_ready_i),
    .notif_src_o   (notif_src_o),
    .push_w        (push_w),
    .fifo_full_w   (fifo_full_w),
    .pq_i          (pq_q)
);

// File: tb/test_evsrc_pq_array.sv
module test_evsrc_pq_array;

    localparam int NSRC  = 4;
    localparam int DEPTH = 2;
    localparam int SW    = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] trig_i = '0;
    logic [NSRC-1:0] line_i = '0;
    logic [NSRC-1:0] level_mode_i = 4'b1000;
    logic            store_eoi_en_i = 1'b1;
    logic            acc_valid_i = 1'b0;
    logic            acc_ready_o;
    logic            acc_write_i = 1'b0;
    logic [SW-1:0]   acc_src_i = '0;
    logic [11:0]     acc_ofs_i = '0;
    logic            acc_rvalid_o;
    logic [63:0]     acc_rdata_o;
    logic            notif_valid_o;
    logic            notif_ready_i = 1'b0;
    logic [SW-1:0]   notif_src_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    evsrc_pq_array #(.NUM_SRC(NSRC), .FIFO_DEPTH(DEPTH)) i_evsrc_pq_array (
        .clk, .rst_n, .trig_i, .line_i, .level_mode_i, .store_eoi_en_i,
        .acc_valid_i, .acc_ready_o, .acc_write_i, .acc_src_i, .acc_ofs_i,
        .acc_rvalid_o, .acc_rdata_o, .notif_valid_o, .notif_ready_i, .notif_src_o
    );

    // kind: 0 trigger, 1 load, 2 store
    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  src;
        logic [11:0] ofs;
        logic        bad;
        logic [2:0]  rd;
        logic        notif;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 2'd1, 12'h800, 1'b0, 3'b000, 1'b0},
        '{2'd0, 2'd1, 12'h000, 1'b0, 3'b000, 1'b1},
        '{2'd0, 2'd1, 12'h000, 1'b0, 3'b000, 1'b0},
        '{2'd0, 2'd1, 12'h000, 1'b0, 3'b000, 1'b0},
        '{2'd1, 2'd1, 12'h800, 1'b0, 3'b011, 1'b0},
        '{2'd1, 2'd1, 12'h000, 1'b0, 3'b011, 1'b1},
        '{2'd1, 2'd1, 12'h000, 1'b0, 3'b010, 1'b0},
        '{2'd1, 2'd1, 12'h800, 1'b0, 3'b000, 1'b0},
        '{2'd1, 2'd1, 12'hD00, 1'b0, 3'b000, 1'b0},
        '{2'd0, 2'd1, 12'h000, 1'b0, 3'b000, 1'b0},
        '{2'd1, 2'd1, 12'hE00, 1'b0, 3'b001, 1'b0},
        '{2'd1, 2'd1, 12'hF00, 1'b0, 3'b010, 1'b0},
        '{2'd2, 2'd1, 12'h400, 1'b0, 3'b000, 1'b1},
        '{2'd2, 2'd1, 12'h200, 1'b0, 3'b000, 1'b0},
        '{2'd1, 2'd1, 12'h800, 1'b0, 3'b010, 1'b0},
        '{2'd2, 2'd1, 12'h400, 1'b0, 3'b000, 1'b0},
        '{2'd1, 2'd1, 12'h123, 1'b1, 3'b000, 1'b0},
        '{2'd1, 2'd1, 12'h800, 1'b0, 3'b000, 1'b0},
        '{2'd1, 2'd1, 12'hC00, 1'b0, 3'b000, 1'b0}
    };

    function automatic string tag_of(vec_t v);
        if (v.kind == 2'd0) return "R2";
        if (v.kind == 2'd2) return "R7";
        if (v.bad) return "R8";
        if (v.ofs == 12'h000) return "R3";
        if (v.ofs == 12'h800) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [SW-1:0] src, input logic [11:0] ofs,
                           output logic [63:0] rd);
        @(negedge clk);
        acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_src_i = src; acc_ofs_i = ofs;
        @(negedge clk);
        acc_valid_i = 1'b0;
        check("R4 rvalid", {63'b0, acc_rvalid_o}, 64'd1);
        rd = acc_rdata_o;
    endtask

    task automatic do_store(input logic [SW-1:0] src, input logic [11:0] ofs);
        @(negedge clk);
        acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_src_i = src; acc_ofs_i = ofs;
        @(negedge clk);
        acc_valid_i = 1'b0; acc_write_i = 1'b0;
        check("R7 no response", {63'b0, acc_rvalid_o}, 64'd0);
    endtask

    task automatic pulse_trig(input logic [NSRC-1:0] mask);
        @(negedge clk);
        trig_i = mask;
        @(negedge clk);
        trig_i = '0;
        @(negedge clk);
    endtask

    task automatic pop_expect(string tag, input logic [SW-1:0] src);
        check({tag, " notif valid"}, {63'b0, notif_valid_o}, 64'd1);
        check({tag, " notif src"}, {62'b0, notif_src_o}, {62'b0, src});
        notif_ready_i = 1'b1;
        @(negedge clk);
        notif_ready_i = 1'b0;
    endtask

    task automatic expect_none(string tag);
        check({tag, " no notif"}, {63'b0, notif_valid_o}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        check("R1 notif idle", {63'b0, notif_valid_o}, 64'd0);
        check("R1 port ready", {63'b0, acc_ready_o}, 64'd1);
        check("R1 no response", {63'b0, acc_rvalid_o}, 64'd0);
        for (int s = 0; s < NSRC; s++) begin
            do_load(SW'(s), 12'h800, rd);
            check("R1 state 00", rd, 64'd0);
        end

        // Vector table on edge source 1
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            unique case (v.kind)
                2'd0: pulse_trig(NSRC'(1) << v.src);
                2'd1: begin
                    do_load(v.src, v.ofs, rd);
                    check({tag_of(v), " R4 load data"}, rd,
                          v.bad ? {64{1'b1}} : {61'b0, v.rd});
                end
                default: do_store(v.src, v.ofs);
            endcase
            if (v.notif) pop_expect(tag_of(v), v.src);
            else expect_none(tag_of(v));
        end

        // R9 / R11: three simultaneous triggers into a two-entry queue
        pulse_trig(4'b0111);
        repeat (3) @(negedge clk);
        check("R9 port held off when full", {63'b0, acc_ready_o}, 64'd0);
        check("R9 head stable", {62'b0, notif_src_o}, 64'd0);
        repeat (2) @(negedge clk);
        check("R9 head still stable", {62'b0, notif_src_o}, 64'd0);
        pop_expect("R11 first", 2'd0);
        @(negedge clk);
        pop_expect("R11 second", 2'd1);
        pop_expect("R9 waiting request kept", 2'd2);
        expect_none("R9 drained");
        for (int s = 0; s < 3; s++) begin
            do_load(SW'(s), 12'h000, rd);
            check("R3 eoi from pend", rd, 64'b010);
            expect_none("R3 eoi pend");
        end

        // R7: store-EOI disabled is ignored
        store_eoi_en_i = 1'b0;
        pulse_trig(4'b0100);
        pop_expect("R2 trigger src2", 2'd2);
        do_store(2'd2, 12'h400);
        expect_none("R7 disabled store");
        do_load(2'd2, 12'h800, rd);
        check("R7 disabled store keeps state", rd, 64'b010);
        store_eoi_en_i = 1'b1;
        do_load(2'd2, 12'h000, rd);
        check("R3 eoi after disabled store", rd, 64'b010);

        // R10: level source 3
        do_load(2'd3, 12'h800, rd);
        check("R10 idle level", rd, 64'b000);
        @(negedge clk);
        line_i[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pop_expect("R10 rising line", 2'd3);
        do_load(2'd3, 12'h800, rd);
        check("R10 assertion bit", rd, 64'b110);
        do_load(2'd3, 12'h000, rd);
        check("R10 eoi while asserted", rd, 64'b110);
        pop_expect("R10 re-notify", 2'd3);
        line_i[3] = 1'b0;
        @(negedge clk);
        do_load(2'd3, 12'h000, rd);
        check("R10 eoi after release", rd, 64'b010);
        expect_none("R10 released");
        do_load(2'd3, 12'h800, rd);
        check("R10 back to idle", rd, 64'b000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule